// File: doc/BRIEF.md
# Two-Level Write-Protection Register Bank for a Converter Front End

This block holds the configuration and control registers of a converter peripheral that has a power-up sequence. It sits on a simple single-cycle bus: address, write strobe, write data and registered read data. Two nested locks protect the registers. A software-set gate bit freezes the configuration group. A read-only lock flag freezes the register that holds the gate bit. Hardware raises the lock flag when the peripheral powers up and drops it when the peripheral powers off.

A mode bit selects the power-up trigger. With the software source, a write of 1 to the power bit starts the peripheral and raises the lock flag at once. With the sequencer source, a level-high arm input starts the peripheral. The lock flag then follows after a delay that runs in two clock domains: the request crosses into the PLL clock domain, a PLL-domain counter runs, completion crosses back through a synchronizer, and a short system-clock delay finishes the sequence. Optionally, setting the gate bit can itself start the peripheral. This option is refused when the no-settle option is on. Blocked writes finish normally on the bus and leave the register unchanged. Every register can always be read.

Top module: `wp_lock_ctrl`

## Requirements
- R1: After the synchronous active-high reset, every address reads 0, and `pwr_up` and `locked` are 0.
- R2: The configuration group is addresses 0, 1, 2, 7, 8, 9 and 10. A write to one of them is stored when gate (address 3 bit 0) is 0. The write is ignored when gate is 1.
- R3: Address 6 (gain) accepts every write, including while gate is 1 and while the peripheral is powered and locked.
- R4: The source bit is address 0 bit 0. With source 0 and the peripheral off, writing 1 to address 4 bit 0 sets `pwr_up` and `locked` together in the next cycle. Address 4 bit 0 reads the power state and address 5 bit 0 reads the lock flag.
- R5: While `locked` is 1, writes to address 3 are ignored. While `locked` is 0, they are stored.
- R6: While powered, writing 0 to address 4 bit 0 clears `pwr_up` and `locked` in the next cycle. Address 3 can then be written again. `locked` is never 1 while `pwr_up` is 0.
- R7: With source 1, a write of 1 to address 4 does not power up. While the peripheral is off, a high `arm` input sets `pwr_up` in the next cycle. `locked` follows 24 to 32 system cycles later, after a 40-cycle PLL-domain count, a 2-flop synchronizer and a 4-cycle system delay.
- R8: Address 0 bit 2 is gate-start and bit 1 is no-settle. With source 0, gate-start 1 and no-settle 0, a write that changes gate from 0 to 1 also powers up and locks in the next cycle. With no-settle 1, the same write stores gate but does not power up.
- R9: Address 5 is read-only and ignores writes. Addresses 11 to 15 read 0 and ignore writes.
- R10: `rdata` is registered. After each clock edge it shows the register addressed in the cycle before, as it was before any write in that cycle took effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pll_clk | input | 1 | PLL clock for the sequencer delay |
| rst | input | 1 | Synchronous active-high reset (system domain) |
| addr | input | ADDR_W | Register address |
| we | input | 1 | Write strobe |
| wdata | input | DATA_W | Write data |
| arm | input | 1 | Sequencer arm (power-up trigger when source is 1) |
| rdata | output | DATA_W | Registered read data |
| pwr_up | output | 1 | Peripheral power state |
| locked | output | 1 | Lock flag |

## Verification
The assertions check the lock invariants on every cycle:
- the lock flag never stands without power;
- the lock flag falls together with power;
- the gate bit cannot move while locked;
- the mode register cannot move while gate is set;
- a software power-up locks at once;
- no power-up happens in sequencer mode without arm.

Only the bench scenarios can show the rest:
- the exact read data of each address class;
- that blocked writes leave the stored value intact;
- that the gate-start path is refused under no-settle;
- that the cross-domain lock delay lands inside its window.

// File: rtl/wp_lock_pkg.sv
package wp_lock_pkg;

  typedef enum logic [2:0] {
    PK_OPEN,
    PK_CFG,
    PK_GATE,
    PK_PWR,
    PK_STAT,
    PK_NONE
  } prot_e;

  localparam int unsigned A_MODE = 0;
  localparam int unsigned A_GATE = 3;
  localparam int unsigned A_PWR  = 4;
  localparam int unsigned A_STAT = 5;
  localparam int unsigned A_GAIN = 6;

  localparam int unsigned MODE_SRC       = 0;
  localparam int unsigned MODE_NOSETTLE  = 1;
  localparam int unsigned MODE_GATESTART = 2;
  localparam int unsigned GATE_BIT       = 0;
  localparam int unsigned PWR_BIT        = 0;

  function automatic prot_e prot_of(int unsigned a);
    case (a)
      0, 1, 2, 7, 8, 9, 10: prot_of = PK_CFG;
      A_GATE:               prot_of = PK_GATE;
      A_PWR:                prot_of = PK_PWR;
      A_STAT:               prot_of = PK_STAT;
      A_GAIN:               prot_of = PK_OPEN;
      default:              prot_of = PK_NONE;
    endcase
  endfunction

endpackage

// File: rtl/wp_sync.sv
module wp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh = '0;

  always_ff @(posedge clk) begin
    sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/wp_regbank.sv
module wp_regbank
  import wp_lock_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pwr_state,
  input  logic              locked,
  output logic [DATA_W-1:0] rdata,
  output logic              gate,
  output logic              gate_rise_wr,
  output logic              pwr_wr,
  output logic              src_seq,
  output logic              no_settle,
  output logic              gate_start
);
  localparam int NREG = 2 ** ADDR_W;

  logic [DATA_W-1:0] slot_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    localparam prot_e P = prot_of(i);
    if (P == PK_CFG || P == PK_OPEN || P == PK_GATE) begin : g_store
      logic [DATA_W-1:0] q;
      logic              allow;
      if (P == PK_CFG) begin : g_cfg
        assign allow = !gate;
      end else if (P == PK_GATE) begin : g_gate
        assign allow = !locked;
      end else begin : g_open
        assign allow = 1'b1;
      end
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= '0;
        end else if (we && addr == ADDR_W'(i) && allow) begin
          q <= wdata;
        end
      end
      assign slot_q[i] = q;
    end else if (P == PK_PWR) begin : g_pwr
      assign slot_q[i] = {{(DATA_W-1){1'b0}}, pwr_state};
    end else if (P == PK_STAT) begin : g_stat
      assign slot_q[i] = {{(DATA_W-1){1'b0}}, locked};
    end else begin : g_none
      assign slot_q[i] = '0;
    end
  end

  assign gate       = slot_q[A_GATE][GATE_BIT];
  assign src_seq    = slot_q[A_MODE][MODE_SRC];
  assign no_settle  = slot_q[A_MODE][MODE_NOSETTLE];
  assign gate_start = slot_q[A_MODE][MODE_GATESTART];

  assign gate_rise_wr = we && addr == ADDR_W'(A_GATE) && !locked
                        && wdata[GATE_BIT] && !gate;
  assign pwr_wr       = we && addr == ADDR_W'(A_PWR);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= slot_q[addr];
    end
  end
endmodule

// File: rtl/wp_pll_delay.sv
module wp_pll_delay #(
  parameter int PLL_CNT = 40,
  parameter int STAGES  = 2
) (
  input  logic pll_clk,
  input  logic rst_pll,
  input  logic req_async,
  output logic done
);
  localparam int CW = $clog2(PLL_CNT);

  logic          req_s;
  logic [CW-1:0] cnt;

  wp_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(pll_clk),
    .d  (req_async),
    .q  (req_s)
  );

  always_ff @(posedge pll_clk) begin
    if (rst_pll || !req_s) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt == CW'(PLL_CNT - 1)) begin
        done <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wp_power_seq.sv
module wp_power_seq #(
  parameter int SYS_DLY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_wr,
  input  logic pwr_wbit,
  input  logic gate_rise_wr,
  input  logic src_seq,
  input  logic no_settle,
  input  logic gate_start,
  input  logic arm,
  input  logic seq_done,
  output logic pwr_state,
  output logic locked,
  output logic seq_req
);
  localparam int DW = $clog2(SYS_DLY + 1);

  logic          sw_trig;
  logic          seq_trig;
  logic          pwr_off;
  logic          dly_end;
  logic [DW-1:0] dly_cnt;

  assign sw_trig  = !src_seq && !pwr_state &&
                    ((pwr_wr && pwr_wbit) ||
                     (gate_rise_wr && gate_start && !no_settle));
  assign seq_trig = src_seq && !pwr_state && arm;
  assign pwr_off  = pwr_state && pwr_wr && !pwr_wbit;
  assign dly_end  = seq_req && seq_done && dly_cnt == DW'(SYS_DLY - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_state <= 1'b0;
      locked    <= 1'b0;
      seq_req   <= 1'b0;
      dly_cnt   <= '0;
    end else begin
      if (sw_trig || seq_trig) begin
        pwr_state <= 1'b1;
      end else if (pwr_off) begin
        pwr_state <= 1'b0;
      end

      if (pwr_off) begin
        locked <= 1'b0;
      end else if (sw_trig || dly_end) begin
        locked <= 1'b1;
      end

      if (seq_trig) begin
        seq_req <= 1'b1;
      end else if (pwr_off || dly_end) begin
        seq_req <= 1'b0;
      end

      if (!seq_req || pwr_off || dly_end) begin
        dly_cnt <= '0;
      end else if (seq_done) begin
        dly_cnt <= dly_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wp_lock_ctrl.sv
module wp_lock_ctrl
  import wp_lock_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 4,
  parameter int PLL_CNT = 40,
  parameter int SYS_DLY = 4,
  parameter int STAGES  = 2
) (
  input  logic              clk,
  input  logic              pll_clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              arm,
  output logic [DATA_W-1:0] rdata,
  output logic              pwr_up,
  output logic              locked
);
  logic gate_q;
  logic gate_rise_wr;
  logic pwr_wr;
  logic src_sel;
  logic no_settle;
  logic gate_start;
  logic seq_req;
  logic done_pll;
  logic done_sys;
  logic rst_pll;

  wp_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .addr        (addr),
    .we          (we),
    .wdata       (wdata),
    .pwr_state   (pwr_up),
    .locked      (locked),
    .rdata       (rdata),
    .gate        (gate_q),
    .gate_rise_wr(gate_rise_wr),
    .pwr_wr      (pwr_wr),
    .src_seq     (src_sel),
    .no_settle   (no_settle),
    .gate_start  (gate_start)
  );

  wp_power_seq #(.SYS_DLY(SYS_DLY)) u_pwr (
    .clk         (clk),
    .rst         (rst),
    .pwr_wr      (pwr_wr),
    .pwr_wbit    (wdata[PWR_BIT]),
    .gate_rise_wr(gate_rise_wr),
    .src_seq     (src_sel),
    .no_settle   (no_settle),
    .gate_start  (gate_start),
    .arm         (arm),
    .seq_done    (done_sys),
    .pwr_state   (pwr_up),
    .locked      (locked),
    .seq_req     (seq_req)
  );

  wp_sync #(.STAGES(STAGES)) u_rst_sync (
    .clk(pll_clk),
    .d  (rst),
    .q  (rst_pll)
  );

  wp_pll_delay #(.PLL_CNT(PLL_CNT), .STAGES(STAGES)) u_pll (
    .pll_clk  (pll_clk),
    .rst_pll  (rst_pll),
    .req_async(seq_req),
    .done     (done_pll)
  );

  wp_sync #(.STAGES(STAGES)) u_done_sync (
    .clk(clk),
    .d  (done_pll),
    .q  (done_sys)
  );
endmodule

// File: rtl/wp_lock_ctrl_chk.sv
module wp_lock_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic pwr_up,
  input logic locked,
  input logic gate_q,
  input logic src_sel,
  input logic arm
);
  AST_LOCK_NEEDS_PWR: assert property (@(posedge clk) disable iff (rst)
    locked |-> pwr_up); // R6

  AST_LOCK_FALLS_WITH_PWR: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_up) |-> !locked); // R6

  AST_GATE_HELD_LOCKED: assert property (@(posedge clk) disable iff (rst)
    $past(locked) |-> gate_q == $past(gate_q)); // R5

  AST_MODE_HELD_GATED: assert property (@(posedge clk) disable iff (rst)
    $past(gate_q) |-> $stable(src_sel)); // R2

  AST_SW_LOCK_AT_ONCE: assert property (@(posedge clk) disable iff (rst)
    ($rose(pwr_up) && !$past(src_sel)) |-> locked); // R4

  AST_SEQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    ($past(src_sel) && !$past(arm) && !$past(pwr_up)) |-> !pwr_up); // R7
endmodule

bind wp_lock_ctrl wp_lock_ctrl_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .pwr_up (pwr_up),
  .locked (locked),
  .gate_q (gate_q),
  .src_sel(src_sel),
  .arm    (arm)
);

// File: tb/wp_lock_ctrl_test.sv
`timescale 1ns/1ps
module wp_lock_ctrl_test;
  logic        clk = 0;
  logic        pll_clk = 0;
  logic        rst = 1;
  logic [3:0]  addr = '0;
  logic        we = 0;
  logic [15:0] wdata = '0;
  logic        arm = 0;
  logic [15:0] rdata;
  logic        pwr_up;
  logic        locked;

  always #2 clk = ~clk;
  always #1 pll_clk = ~pll_clk;

  wp_lock_ctrl uut (
    .clk(clk), .pll_clk(pll_clk), .rst(rst), .addr(addr), .we(we),
    .wdata(wdata), .arm(arm), .rdata(rdata), .pwr_up(pwr_up), .locked(locked)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] m [16];
  bit m_pwr, m_lock, m_pend;
  int pend_cnt;

  function automatic logic [15:0] mread(logic [3:0] a);
    if (a == 4) return {15'd0, m_pwr};
    if (a == 5) return {15'd0, m_lock};
    if (a >= 11) return 16'd0;
    return m[a];
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit w, logic [3:0] a, logic [15:0] d, bit arm_v, string tag);
    logic [15:0] exp_rd;
    bit g, src, nos, gst, pw, lk;
    exp_rd = mread(a);
    g = m[3][0]; src = m[0][0]; nos = m[0][1]; gst = m[0][2];
    pw = m_pwr; lk = m_lock;
    we = w; addr = a; wdata = d; arm = arm_v;
    if (w) begin
      case (a)
        0, 1, 2, 7, 8, 9, 10: if (!g) m[a] = d;
        3: if (!lk) begin
             if (d[0] && !g && !src && gst && !nos && !pw) begin
               m_pwr = 1; m_lock = 1;
             end
             m[3] = d;
           end
        4: begin
             if (d[0] && !src && !pw) begin m_pwr = 1; m_lock = 1; end
             else if (!d[0] && pw) begin m_pwr = 0; m_lock = 0; m_pend = 0; end
           end
        6: m[6] = d;
        default: ;
      endcase
    end
    if (src && !pw && arm_v) begin m_pwr = 1; m_pend = 1; pend_cnt = 0; end
    @(posedge clk);
    @(negedge clk);
    we = 0;
    chk(tag, "rdata", rdata, exp_rd);
    chk(tag, "pwr_up", {15'd0, pwr_up}, {15'd0, m_pwr});
    if (m_pend) begin
      pend_cnt++;
      if (locked) begin
        checks++;
        if (pend_cnt < 24 || pend_cnt > 32) begin
          errors++;
          $display("FAIL R7 lock delay actual=%0d expected=24..32", pend_cnt);
        end
        m_lock = 1; m_pend = 0;
      end else if (pend_cnt > 40) begin
        checks++; errors++;
        $display("FAIL R7 lock delay actual=%0d expected=24..32", pend_cnt);
        m_pend = 0;
      end
    end else begin
      chk(tag, "locked", {15'd0, locked}, {15'd0, m_lock});
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m[i] = '0;
    m_pwr = 0; m_lock = 0; m_pend = 0; pend_cnt = 0;
    repeat (6) @(negedge clk);
    rst = 0;
    // R1: reset state of every address
    for (int i = 0; i < 16; i++) cyc(0, 4'(i), 0, 0, "R1");
    // R2 R10: configuration group writable while gate is 0
    cyc(1, 0, 16'h0000, 0, "R2");
    for (int i = 1; i < 11; i++)
      if (i != 3 && i != 4 && i != 5 && i != 6) cyc(1, 4'(i), 16'hA500 + 16'(i), 0, "R2");
    cyc(1, 2, 16'h1234, 0, "R10");
    cyc(0, 2, 0, 0, "R10");
    cyc(0, 2, 0, 0, "R10");
    for (int i = 0; i < 11; i++) cyc(0, 4'(i), 0, 0, "R2");
    // R9: read-only and unmapped addresses
    cyc(1, 5, 16'hFFFF, 0, "R9");
    cyc(0, 5, 0, 0, "R9");
    cyc(1, 12, 16'hBEEF, 0, "R9");
    cyc(0, 12, 0, 0, "R9");
    cyc(0, 15, 0, 0, "R9");
    // R3: gain open
    cyc(1, 6, 16'h0077, 0, "R3");
    cyc(0, 6, 0, 0, "R3");
    // R2: gate set freezes group
    cyc(1, 3, 16'h0001, 0, "R5");
    cyc(1, 1, 16'h5555, 0, "R2");
    cyc(1, 8, 16'h6666, 0, "R2");
    cyc(1, 0, 16'h0007, 0, "R2");
    cyc(0, 1, 0, 0, "R2");
    cyc(0, 8, 0, 0, "R2");
    cyc(0, 0, 0, 0, "R2");
    cyc(1, 6, 16'h0099, 0, "R3");
    cyc(0, 6, 0, 0, "R3");
    // R4: software power-up
    cyc(1, 4, 16'h0001, 0, "R4");
    cyc(0, 4, 0, 0, "R4");
    cyc(0, 5, 0, 0, "R4");
    // R5: gate register locked
    cyc(1, 3, 16'h0000, 0, "R5");
    cyc(0, 3, 0, 0, "R5");
    cyc(1, 6, 16'h0123, 0, "R3");
    cyc(0, 6, 0, 0, "R3");
    // R6: power off clears lock, gate writable again
    cyc(1, 4, 16'h0000, 0, "R6");
    cyc(0, 5, 0, 0, "R6");
    cyc(1, 3, 16'h0000, 0, "R6");
    cyc(0, 3, 0, 0, "R6");
    cyc(1, 1, 16'h4321, 0, "R2");
    cyc(0, 1, 0, 0, "R2");
    // R7: sequencer source
    cyc(1, 0, 16'h0001, 0, "R7");
    cyc(1, 4, 16'h0001, 0, "R7");
    cyc(0, 4, 0, 0, "R7");
    cyc(0, 1, 0, 1, "R7");
    for (int i = 0; i < 45 && m_pend; i++) cyc(0, 1, 0, 0, "R7");
    cyc(0, 5, 0, 0, "R7");
    cyc(1, 3, 16'h0001, 0, "R7");
    cyc(0, 3, 0, 0, "R7");
    cyc(1, 4, 16'h0000, 0, "R6");
    cyc(0, 5, 0, 0, "R6");
    // R8: gate as trigger
    cyc(1, 0, 16'h0004, 0, "R8");
    cyc(1, 3, 16'h0001, 0, "R8");
    cyc(0, 5, 0, 0, "R8");
    cyc(1, 4, 16'h0000, 0, "R8");
    cyc(1, 3, 16'h0000, 0, "R8");
    cyc(1, 0, 16'h0006, 0, "R8");
    cyc(1, 3, 16'h0001, 0, "R8");
    cyc(0, 3, 0, 0, "R8");
    cyc(0, 4, 0, 0, "R8");
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule